// File: doc/BRIEF.md
# Lane-Parallel Rounding Shift-Right Accumulator

This block shifts every element of a packed vector right by an immediate amount. The element width can be 8, 16, 32 or 64 bits. The shift can be arithmetic or logical. Before the shift, the block can add a half-LSB rounding term, and after the shift it can add the shifted value into the matching element of a prior destination vector. A scalar mode works on element 0 only, and a half-width register mode produces only the low 64 bits.

One operation is issued per cycle with `in_valid`. The 128-bit result is registered and appears with `out_valid` on the following clock edge. While no operation is issued, the result register holds its value. Narrowing and saturation are not performed: every arithmetic step wraps within the element width.

Top module: `vsr_unit`

## Requirements
- R1: `elem_size` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies result bits [i*W +: W], and each element is computed independently of its neighbours.
- R2: With `is_signed`=0 the shift is logical. The valid shift range is 1..W, and a shift of W with no rounding gives 0.
- R3: With `is_signed`=1 the shift is arithmetic. A shift of W with no rounding gives all ones for a negative element and 0 otherwise.
- R4: With `do_round`=1, 2^(sh-1) is added before the shift and the carry is kept. The result equals the unrounded shift plus bit (sh-1) of the source element, wrapped to W bits. For example, an unsigned 0xFF shifted by 1 gives 0x80, and an all-ones 64-bit element gives 0x8000000000000000.
- R5: With `do_accum`=1, the shifted value is added to the same element of `dst_vec`, modulo 2^W, with no saturation.
- R6: With `wide_reg`=0, result bits [127:64] are 0. With `wide_reg`=1, all 128/W elements are produced.
- R7: With `scalar_mode`=1, only element 0 is produced and every other result bit is 0, whatever `wide_reg` is.
- R8: `result` and `out_valid` update on the clock edge after `in_valid` is sampled high. `out_valid` is high for exactly the cycles that follow an issue, and `result` holds when `in_valid` is low.
- R9: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| src_vec | input | 128 | Source vector to shift |
| dst_vec | input | 128 | Prior destination, the accumulation addend |
| elem_size | input | 2 | Element width code |
| shift_amt | input | 7 | Right-shift immediate, 1..W |
| is_signed | input | 1 | 1 selects an arithmetic shift |
| do_round | input | 1 | Add the half-LSB rounding term |
| do_accum | input | 1 | Add the result into the destination element |
| scalar_mode | input | 1 | Operate on element 0 only |
| wide_reg | input | 1 | 1 selects a 128-bit register, 0 a 64-bit register |
| out_valid | output | 1 | Result is from an operation issued last cycle |
| result | output | 128 | Registered result vector |

## Verification
The checker enforces four things on every cycle:
- the one-cycle valid timing and result hold when idle;
- the cleared upper half in half-width and scalar forms;
- the cleared bits above element 0 in scalar mode;
- the zero result of an unsigned full-width shift.

Only the bench's vectors can show the arithmetic itself: the rounding carry at 64 bits, the sign fill, the wrap of accumulation, and the independence of lanes with mixed patterns.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  typedef struct packed {
    logic is_signed;
    logic do_round;
    logic do_accum;
  } lane_ctrl_t;

  localparam int unsigned MIN_EW = 8;
  localparam int unsigned N_SIZES = 4;

  function automatic int unsigned elem_bytes(input logic [1:0] code);
    return (MIN_EW / 8) << code;
  endfunction

endpackage

// File: rtl/vsr_lane.sv
module vsr_lane
  import vsr_pkg::*;
#(
  parameter int unsigned EW  = 8,
  parameter int unsigned SHW = 7
) (
  input  logic [EW-1:0]  src,
  input  logic [EW-1:0]  dst,
  input  logic [SHW-1:0] sh,
  input  lane_ctrl_t     ctrl,
  output logic [EW-1:0]  res
);
  localparam int unsigned XW = EW + 1;

  logic [XW-1:0] ext;
  logic [XW-1:0] rnd;
  logic [XW-1:0] sum;
  logic [XW-1:0] shf;
  logic [EW-1:0] addend;

  always_comb begin
    ext = {ctrl.is_signed & src[EW-1], src};
    rnd = '0;
    if (ctrl.do_round && (sh != '0)) begin
      rnd = XW'(1) << (sh - SHW'(1));
    end
    sum = ext + rnd;
    if (ctrl.is_signed) begin
      shf = XW'($signed(sum) >>> sh);
    end else begin
      shf = sum >> sh;
    end
    addend = ctrl.do_accum ? dst : '0;
    res    = shf[EW-1:0] + addend;
  end

endmodule

// File: rtl/vsr_lane_bank.sv
module vsr_lane_bank
  import vsr_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 8,
  parameter int unsigned SHW   = 7
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [SHW-1:0]   sh,
  input  lane_ctrl_t       ctrl,
  output logic [VEC_W-1:0] res
);
  localparam int unsigned NLANE = VEC_W / EW;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    vsr_lane #(.EW(EW), .SHW(SHW)) u_lane (
      .src  (src[i*EW +: EW]),
      .dst  (dst[i*EW +: EW]),
      .sh   (sh),
      .ctrl (ctrl),
      .res  (res[i*EW +: EW])
    );
  end

endmodule

// File: rtl/vsr_keep_mask.sv
module vsr_keep_mask
  import vsr_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [1:0]       elem_size,
  input  logic             scalar_mode,
  input  logic             wide_reg,
  output logic [VEC_W-1:0] keep
);
  localparam int unsigned NBYTE = VEC_W / 8;
  localparam int unsigned HALF_BYTES = NBYTE / 2;

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      if (scalar_mode) begin
        keep[b*8 +: 8] = {8{32'(b) < elem_bytes(elem_size)}};
      end else begin
        keep[b*8 +: 8] = {8{wide_reg || (32'(b) < HALF_BYTES)}};
      end
    end
  end

endmodule

// File: rtl/vsr_unit.sv
module vsr_unit
  import vsr_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned MAX_EW = 64,
  localparam int unsigned SHW   = $clog2(MAX_EW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [1:0]       elem_size,
  input  logic [SHW-1:0]   shift_amt,
  input  logic             is_signed,
  input  logic             do_round,
  input  logic             do_accum,
  input  logic             scalar_mode,
  input  logic             wide_reg,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  lane_ctrl_t       ctrl;
  logic [VEC_W-1:0] bank_res [N_SIZES];
  logic [VEC_W-1:0] keep;
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] res_d;
  logic             vld_d;

  assign ctrl = '{is_signed: is_signed, do_round: do_round, do_accum: do_accum};

  for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
    vsr_lane_bank #(
      .VEC_W (VEC_W),
      .EW    (MIN_EW << g),
      .SHW   (SHW)
    ) u_bank (
      .src  (src_vec),
      .dst  (dst_vec),
      .sh   (shift_amt),
      .ctrl (ctrl),
      .res  (bank_res[g])
    );
  end

  vsr_keep_mask #(.VEC_W(VEC_W)) u_mask (
    .elem_size   (elem_size),
    .scalar_mode (scalar_mode),
    .wide_reg    (wide_reg),
    .keep        (keep)
  );

  always_comb begin
    unique case (esize_e'(elem_size))
      ESZ_8:   picked = bank_res[0];
      ESZ_16:  picked = bank_res[1];
      ESZ_32:  picked = bank_res[2];
      default: picked = bank_res[3];
    endcase
    vld_d = in_valid;
    res_d = result;
    if (in_valid) begin
      res_d = picked & keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= vld_d;
      if (in_valid) begin
        result <= res_d;
      end
    end
  end

endmodule

// File: rtl/vsr_unit_checker.sv
module vsr_unit_checker #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SHW   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       elem_size,
  input logic [SHW-1:0]   shift_amt,
  input logic             is_signed,
  input logic             do_round,
  input logic             do_accum,
  input logic             scalar_mode,
  input logic             wide_reg,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam int unsigned HALF = VEC_W / 2;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_drops_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_upper_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!wide_reg || scalar_mode)) |=> (result[VEC_W-1:HALF] == '0));

  assert_scalar_only_elem0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode && elem_size == 2'd0) |=> (result[VEC_W-1:8] == '0));

  assert_full_logical_shift_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_signed && !do_round && !do_accum && elem_size == 2'd0
     && shift_amt == SHW'(8)) |=> (result[7:0] == 8'h00));

endmodule

bind vsr_unit vsr_unit_checker #(.VEC_W(VEC_W), .SHW(SHW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .elem_size   (elem_size),
  .shift_amt   (shift_amt),
  .is_signed   (is_signed),
  .do_round    (do_round),
  .do_accum    (do_accum),
  .scalar_mode (scalar_mode),
  .wide_reg    (wide_reg),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/tb_vsr_unit.sv
module tb_vsr_unit;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [127:0] dst_vec;
  logic [1:0]   elem_size;
  logic [6:0]   shift_amt;
  logic         is_signed;
  logic         do_round;
  logic         do_accum;
  logic         scalar_mode;
  logic         wide_reg;
  logic         out_valid;
  logic [127:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  vsr_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .dst_vec(dst_vec), .elem_size(elem_size), .shift_amt(shift_amt),
    .is_signed(is_signed), .do_round(do_round), .do_accum(do_accum),
    .scalar_mode(scalar_mode), .wide_reg(wide_reg),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector layout: {req[3:0], flags{sgn,rnd,acc,scl,wid}[4:0], size[1:0], sh[6:0], src, dst, exp}
  localparam int NV = 14;
  localparam logic [401:0] VEC [NV] = '{
    // R2 unsigned bytes >>4
    {4'd2, 5'b00001, 2'd0, 7'd4, {16{8'hF0}}, 128'h0, {16{8'h0F}}},
    // R3 signed bytes >>>4
    {4'd3, 5'b10001, 2'd0, 7'd4, {16{8'hF0}}, 128'h0, {16{8'hFF}}},
    // R4 unsigned round 0xFF>>1 -> 0x80
    {4'd4, 5'b01001, 2'd0, 7'd1, {16{8'hFF}}, 128'h0, {16{8'h80}}},
    // R4 64-bit carry kept
    {4'd4, 5'b01001, 2'd3, 7'd1, {128{1'b1}}, 128'h0, {2{64'h8000_0000_0000_0000}}},
    // R5 accumulate wraps in 16 bits
    {4'd5, 5'b00101, 2'd1, 7'd8, {8{16'h1234}}, {8{16'hFFF0}}, {8{16'h0002}}},
    // R6 half-width register clears upper half
    {4'd6, 5'b00000, 2'd2, 7'd4, {4{32'h8765_4321}}, 128'h0, {64'h0, {2{32'h0876_5432}}}},
    // R7 scalar signed byte
    {4'd7, 5'b10011, 2'd0, 7'd1, {16{8'h86}}, 128'h0, {120'h0, 8'hC3}},
    // R2 shift equal to width gives zero
    {4'd2, 5'b00001, 2'd2, 7'd32, {128{1'b1}}, 128'h0, 128'h0},
    // R3 shift equal to width gives sign fill
    {4'd3, 5'b10001, 2'd3, 7'd64, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, 128'h0,
     {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}},
    // R4 signed round -6 >> 2 -> -1
    {4'd4, 5'b11001, 2'd1, 7'd2, {8{16'hFFFA}}, 128'h0, {8{16'hFFFF}}},
    // R4 unsigned round with shift equal to width
    {4'd4, 5'b01001, 2'd0, 7'd8, {8{8'h80, 8'h7F}}, 128'h0, {8{8'h01, 8'h00}}},
    // R1 distinct 64-bit lanes
    {4'd1, 5'b00001, 2'd3, 7'd4, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 128'h0,
     {64'h0012_3456_789A_BCDE, 64'h0FED_CBA9_8765_4321}},
    // R5 signed round accumulate wraps
    {4'd5, 5'b11101, 2'd2, 7'd1, {4{32'h0000_0003}}, {4{32'h7FFF_FFFF}}, {4{32'h8000_0001}}},
    // R7 scalar 64-bit accumulate in a wide register
    {4'd7, 5'b00111, 2'd3, 7'd1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h10}, {64'h1234, 64'h5},
     {64'h0, 64'hD}}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [401:0] v);
    @(negedge clk);
    in_valid    = 1'b1;
    exp_unused  = v[127:0];
    dst_vec     = v[255:128];
    src_vec     = v[383:256];
    shift_amt   = v[390:384];
    elem_size   = v[392:391];
    {is_signed, do_round, do_accum, scalar_mode, wide_reg} = v[397:393];
  endtask

  logic [127:0] exp_unused;
  logic [127:0] held;

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R8: watchdog expired, actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; dst_vec = '0; elem_size = '0;
    shift_amt = 7'd1; is_signed = 0; do_round = 0; do_accum = 0;
    scalar_mode = 0; wide_reg = 1; exp_unused = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result in reset", result, 128'h0);
    check("R9 out_valid in reset", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][401:398], i), result, VEC[i][127:0]);
      check("R8 out_valid after issue", {127'h0, out_valid}, 128'h1);
    end

    // R8 hold while idle: inputs change, result must not
    held = result;
    in_valid = 1'b0;
    src_vec = {128{1'b1}};
    elem_size = 2'd0;
    @(negedge clk);
    check("R8 out_valid drops", {127'h0, out_valid}, 128'h0);
    check("R8 result held", result, held);
    @(negedge clk);
    check("R8 result still held", result, held);

    // R6 same op with a wide register keeps the upper half
    issue({4'd6, 5'b00001, 2'd2, 7'd4, {4{32'h8765_4321}}, 128'h0, 128'h0});
    @(negedge clk);
    check("R6 wide keeps upper", result, {4{32'h0876_5432}});

    // R9 reset mid-stream clears result
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 result after reset", result, 128'h0);
    check("R9 out_valid after reset", {127'h0, out_valid}, 128'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule